// File: doc/BRIEF.md
# Framed-Bus Slave UART

This block is a serial-port peripheral that sits as a slave on a 10-bit framed command bus. Each bus word carries a 2-bit kind and an 8-bit payload. A control word latches an operation and a register address. The data words that follow write that register or read it back. A null word returns every programmable register of the peripheral to its reset value.

Behind the bus are an asynchronous transmitter and receiver. Character length, parity and stop count are programmable, and the bit rate comes from a 16-bit divisor. The block also carries three modem inputs, two modem outputs and an 8-bit interrupt status register with a mask. The interrupt line is a level output.

Each interrupt source is cleared by the register access that serves it. Reading a received character clears its flag. Loading a character to send clears the transmitter-empty flag. Reading the line status clears the error/modem-change flag. The serial engines run only while the enable bit of the port-mode register is set.

Top module: `sbu_uart_slave`

## Requirements
- R1: After reset, txd_o is high, rts_o, dtr_o and irq_o are low, the interrupt mask reads 0x00 and the interrupt status holds 0x02.
- R2: A word with bits 9:8 = 01 latches its low byte as the command: bits 7:6 are the operation (01 select, 10 write, 11 read) and bits 3:0 are the register. A word with bits 9:8 = 10 writes its low byte to that register when the operation is write. When the operation is read, the word loads the register's value onto rd_data, visible one clock later. A data word under the select operation changes no register.
- R3: A word with bits 9:8 = 00 resets the mask to 0x00, the status to 0x02, the divisor to 0xFFFF, the port mode, line control and modem outputs to 0, and the receive flags to 0.
- R4: irq_o is high exactly when the interrupt status AND the mask is nonzero. Register 7 reads that AND, and register 6 reads the mask.
- R5: Register 8 written sets the line format: bits 2:1 give 5 plus their value data bits, bit 3 enables parity, bit 4 picks odd parity (even when 0), and bit 5 picks two stop bits. A character is sent as a low start bit, data LSB first, the optional parity bit, then high stop bits. The line idles high.
- R6: The divisor is written low byte at register 0x0A and high byte at 0x0B. Every serial bit lasts 16 × ((65536 − divisor) mod 65536) clock cycles, with 0 meaning 65536.
- R7: A write to register 9 that starts a character clears status bit 1, and the end of the character sets it again. Line-status bit 3 (transmitter empty) and bit 4 (transmitter busy) track the transmitter.
- R8: A received character sets status bit 0 and line-status bit 5 and is read at register 9. That read clears both.
- R9: A low stop bit sets line-status bit 6, and a wrong parity bit sets line-status bit 7. A second character completed before the first is read also sets bit 6. Each of these errors sets status bit 2, and a read of register 8 clears status bit 2.
- R10: Line-status bits 0, 1 and 2 show CTS, DSR and DCD. Any change on one of them sets status bit 2.
- R11: Bit 0 of register 2 enables the serial engines. While it is clear, a write to register 9 sends nothing and leaves status bit 1 set, txd_o stays high, and writes to register 3 leave the modem outputs unchanged. While it is set, a write to register 3 drives rts_o from data bit 1 and dtr_o from data bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | A bus word is present this cycle |
| frm_word | input | 10 | Bus word: kind in bits 9:8, payload in bits 7:0 |
| rd_data | output | 8 | Value returned by the last read data word |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_i | input | 1 | Clear-to-send input |
| dsr_i | input | 1 | Data-set-ready input |
| dcd_i | input | 1 | Carrier-detect input |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong bit counter or a wrong frame length in the transmitter shows on txd_o within one character. The check measures the start-bit length, so a baud-counter fault appears as a bit of the wrong length during that start bit. Receiver faults surface in the line status or the data word, which the bench reads a few dozen cycles after the stop bit. Flags that fail to set or clear show in the next read of register 7 and on irq_o within one cycle of the access that should have changed them.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  typedef enum logic [1:0] {
    FR_NULL = 2'b00,
    FR_CTRL = 2'b01,
    FR_DATA = 2'b10,
    FR_RSVD = 2'b11
  } frame_kind_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SEL  = 2'b01,
    OP_WR   = 2'b10,
    OP_RD   = 2'b11
  } bus_op_e;

  localparam logic [3:0] A_MODE  = 4'h2;
  localparam logic [3:0] A_MODEM = 4'h3;
  localparam logic [3:0] A_IMASK = 4'h6;
  localparam logic [3:0] A_ISTAT = 4'h7;
  localparam logic [3:0] A_LINE  = 4'h8;
  localparam logic [3:0] A_CHAR  = 4'h9;
  localparam logic [3:0] A_DIVLO = 4'hA;
  localparam logic [3:0] A_DIVHI = 4'hB;

  // line format, packed to match payload bits 5:1
  typedef struct packed {
    logic       two_stop;
    logic       par_odd;
    logic       par_en;
    logic [1:0] len_m5;
  } ucfg_t;

  function automatic int data_bits(ucfg_t c);
    return 5 + int'(c.len_m5);
  endfunction

  function automatic int frame_bits(ucfg_t c);
    return 1 + data_bits(c) + int'(c.par_en) + (c.two_stop ? 2 : 1);
  endfunction
endpackage

// File: rtl/sbu_baud.sv
module sbu_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = !clr && (cnt_q == '1);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr || cnt_q == '1) cnt_d = div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sbu_tx.sv
module sbu_tx import sbu_pkg::*; #(
  parameter int DW = 8,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  ucfg_t         cfg,
  output logic          txd,
  output logic          busy,
  output logic          done
);
  logic          pend_q, pend_d, act_q, act_d, done_q, done_d;
  logic [DW-1:0] dat_q, dat_d;
  logic [FW-1:0] sh_q, sh_d, frame;
  logic [3:0]    left_q, left_d, sub_q, sub_d;

  always_comb begin : build
    int   nd;
    logic par;
    nd       = data_bits(cfg);
    frame    = '1;
    frame[0] = 1'b0;
    par      = cfg.par_odd;
    for (int i = 0; i < DW; i++) begin
      if (i < nd) begin
        frame[i+1] = dat_q[i];
        par        = par ^ dat_q[i];
      end
    end
    if (cfg.par_en) frame[nd+1] = par;
  end

  always_comb begin
    pend_d = pend_q; act_d = act_q; dat_d = dat_q; sh_d = sh_q;
    left_d = left_q; sub_d = sub_q; done_d = 1'b0;
    if (clr) begin
      pend_d = 1'b0; act_d = 1'b0; sh_d = '1; left_d = '0; sub_d = '0;
    end else begin
      if (load && !pend_q && !act_q) begin
        pend_d = 1'b1;
        dat_d  = ld_data;
      end
      if (tick && pend_q) begin
        pend_d = 1'b0; act_d = 1'b1; sh_d = frame;
        left_d = 4'(frame_bits(cfg)); sub_d = '0;
      end else if (tick && act_q) begin
        sub_d = sub_q + 4'd1;
        if (sub_q == 4'hF) begin
          if (left_q == 4'd1) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            sh_d   = {1'b1, sh_q[FW-1:1]};
            left_d = left_q - 4'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; act_q <= 1'b0; done_q <= 1'b0; dat_q <= '0;
      sh_q <= '1; left_q <= '0; sub_q <= '0;
    end else begin
      pend_q <= pend_d; act_q <= act_d; done_q <= done_d; dat_q <= dat_d;
      sh_q <= sh_d; left_q <= left_d; sub_q <= sub_d;
    end
  end

  assign txd  = act_q ? sh_q[0] : 1'b1;
  assign busy = pend_q | act_q;
  assign done = done_q;
endmodule

// File: rtl/sbu_rx.sv
module sbu_rx import sbu_pkg::*; #(
  parameter int DW = 8,
  parameter int FW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          rxd,
  input  ucfg_t         cfg,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ferr,
  output logic          perr
);
  logic          act_q, act_d, fin_q, fin_d;
  logic [3:0]    sub_q, sub_d, pos_q, pos_d;
  logic [FW-1:0] sh_q, sh_d;

  always_comb begin
    act_d = act_q; sub_d = sub_q; pos_d = pos_q; sh_d = sh_q; fin_d = 1'b0;
    if (clr) begin
      act_d = 1'b0; sub_d = '0; pos_d = '0;
    end else if (tick) begin
      if (!act_q) begin
        if (!rxd) begin
          act_d = 1'b1; sub_d = '0; pos_d = '0;
        end
      end else begin
        sub_d = sub_q + 4'd1;
        if (sub_q == 4'd7) begin
          if (pos_q == 4'd0 && rxd) begin
            act_d = 1'b0;              // start bit gone high: false start
          end else begin
            sh_d[pos_q] = rxd;
            if (pos_q == 4'(frame_bits(cfg) - 1)) begin
              act_d = 1'b0;
              fin_d = 1'b1;
            end else begin
              pos_d = pos_q + 4'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; fin_q <= 1'b0; sub_q <= '0; pos_q <= '0; sh_q <= '1;
    end else begin
      act_q <= act_d; fin_q <= fin_d; sub_q <= sub_d; pos_q <= pos_d; sh_q <= sh_d;
    end
  end

  always_comb begin : unpack
    int   nd, si;
    logic p;
    nd   = data_bits(cfg);
    data = '0;
    p    = cfg.par_odd;
    for (int i = 0; i < DW; i++) begin
      if (i < nd) begin
        data[i] = sh_q[i+1];
        p       = p ^ sh_q[i+1];
      end
    end
    si   = nd + 1 + int'(cfg.par_en);
    perr = cfg.par_en && (sh_q[nd+1] != p);
    ferr = !sh_q[si] || (cfg.two_stop && !sh_q[si+1]);
  end

  assign done = fin_q;
endmodule

// File: rtl/sbu_uart_slave.sv
module sbu_uart_slave import sbu_pkg::*; #(
  parameter int DW    = 8,
  parameter int DIV_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_vld,
  input  logic [9:0]    frm_word,
  output logic [DW-1:0] rd_data,
  input  logic          rxd_i,
  output logic          txd_o,
  input  logic          cts_i,
  input  logic          dsr_i,
  input  logic          dcd_i,
  output logic          rts_o,
  output logic          dtr_o,
  output logic          irq_o
);
  localparam int FW = DW + 4;
  localparam logic [DW-1:0] IST_RST = DW'(2);

  logic [1:0]       op_q, op_d;
  logic [3:0]       addr_q, addr_d;
  logic             en_q, en_d, rts_q, rts_d, dtr_q, dtr_d;
  logic [DW-1:0]    imask_q, imask_d, ist_q, ist_d, rdat_q, rdat_d, rxbuf_q, rxbuf_d;
  logic             rxfull_q, rxfull_d, ferr_q, ferr_d, perr_q, perr_d, ovr_q, ovr_d;
  ucfg_t            cfg_q, cfg_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       m_s1, m_s2, m_prev;
  logic             r_s1, r_s2;

  logic             is_null, is_ctl, is_dat, wr, rd, tx_accept, rd_rx, rd_st, clr;
  logic             tick, tx_busy, tx_done, rx_done, rx_ferr, rx_perr;
  logic [DW-1:0]    wdat, rx_data, ustat, rmux;

  assign wdat    = frm_word[7:0];
  assign is_null = frm_vld && (frm_word[9:8] == FR_NULL);
  assign is_ctl  = frm_vld && (frm_word[9:8] == FR_CTRL);
  assign is_dat  = frm_vld && (frm_word[9:8] == FR_DATA);
  assign wr      = is_dat && (op_q == OP_WR);
  assign rd      = is_dat && (op_q == OP_RD);
  assign tx_accept = wr && (addr_q == A_CHAR) && en_q && !tx_busy;
  assign rd_rx   = rd && (addr_q == A_CHAR);
  assign rd_st   = rd && (addr_q == A_LINE);
  assign clr     = is_null || !en_q;

  sbu_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(clr), .div(div_q), .tick(tick));

  sbu_tx #(.DW(DW), .FW(FW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .load(tx_accept),
    .ld_data(wdat), .cfg(cfg_q), .txd(txd_o), .busy(tx_busy), .done(tx_done));

  sbu_rx #(.DW(DW), .FW(FW)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .rxd(r_s2), .cfg(cfg_q),
    .done(rx_done), .data(rx_data), .ferr(rx_ferr), .perr(rx_perr));

  assign ustat = {perr_q, ferr_q | ovr_q, rxfull_q, tx_busy, !tx_busy, m_s2};

  always_comb begin
    case (addr_q)
      A_MODE:  rmux = DW'(en_q);
      A_IMASK: rmux = imask_q;
      A_ISTAT: rmux = ist_q & imask_q;
      A_LINE:  rmux = ustat;
      A_CHAR:  rmux = rxbuf_q;
      default: rmux = '0;
    endcase
  end

  always_comb begin
    op_d = op_q; addr_d = addr_q; en_d = en_q; rts_d = rts_q; dtr_d = dtr_q;
    imask_d = imask_q; ist_d = ist_q; rdat_d = rdat_q; rxbuf_d = rxbuf_q;
    rxfull_d = rxfull_q; ferr_d = ferr_q; perr_d = perr_q; ovr_d = ovr_q;
    cfg_d = cfg_q; div_d = div_q;
    if (is_null) begin
      op_d = OP_NONE; addr_d = '0; en_d = 1'b0; rts_d = 1'b0; dtr_d = 1'b0;
      imask_d = '0; ist_d = IST_RST; rxfull_d = 1'b0; ferr_d = 1'b0;
      perr_d = 1'b0; ovr_d = 1'b0; cfg_d = '0; div_d = '1;
    end else begin
      if (is_ctl) begin
        op_d   = wdat[7:6];
        addr_d = wdat[3:0];
      end
      if (wr) begin
        case (addr_q)
          A_MODE:  en_d = wdat[0];
          A_MODEM: if (en_q) begin rts_d = wdat[1]; dtr_d = wdat[2]; end
          A_IMASK: imask_d = wdat;
          A_LINE:  cfg_d = ucfg_t'(wdat[5:1]);
          A_DIVLO: div_d[7:0] = wdat;
          A_DIVHI: div_d[DIV_W-1:8] = wdat[DIV_W-9:0];
          default: ;
        endcase
      end
      if (rd) rdat_d = rmux;
      // clears first, so a set in the same cycle wins
      if (tx_accept) ist_d[1] = 1'b0;
      if (rd_rx) begin ist_d[0] = 1'b0; rxfull_d = 1'b0; end
      if (rd_st) ist_d[2] = 1'b0;
      if (tx_done) ist_d[1] = 1'b1;
      if (rx_done) begin
        ist_d[0] = 1'b1;
        ovr_d    = rxfull_q && !rd_rx;
        rxfull_d = 1'b1;
        rxbuf_d  = rx_data;
        ferr_d   = rx_ferr;
        perr_d   = rx_perr;
        if (rx_ferr || rx_perr || (rxfull_q && !rd_rx)) ist_d[2] = 1'b1;
      end
      if (|(m_s2 ^ m_prev)) ist_d[2] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NONE; addr_q <= '0; en_q <= 1'b0; rts_q <= 1'b0; dtr_q <= 1'b0;
      imask_q <= '0; ist_q <= IST_RST; rdat_q <= '0; rxbuf_q <= '0;
      rxfull_q <= 1'b0; ferr_q <= 1'b0; perr_q <= 1'b0; ovr_q <= 1'b0;
      cfg_q <= '0; div_q <= '1;
    end else begin
      op_q <= op_d; addr_q <= addr_d; en_q <= en_d; rts_q <= rts_d; dtr_q <= dtr_d;
      imask_q <= imask_d; ist_q <= ist_d; rdat_q <= rdat_d; rxbuf_q <= rxbuf_d;
      rxfull_q <= rxfull_d; ferr_q <= ferr_d; perr_q <= perr_d; ovr_q <= ovr_d;
      cfg_q <= cfg_d; div_q <= div_d;
    end
  end

  // input synchronisers, kept across null words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; r_s1 <= 1'b1; r_s2 <= 1'b1;
    end else begin
      m_s1 <= {dcd_i, dsr_i, cts_i}; m_s2 <= m_s1; m_prev <= m_s2;
      r_s1 <= rxd_i; r_s2 <= r_s1;
    end
  end

  assign rd_data = rdat_q;
  assign rts_o   = rts_q;
  assign dtr_o   = dtr_q;
  assign irq_o   = |(ist_q & imask_q);
endmodule

// File: rtl/sbu_uart_chk.sv
module sbu_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_vld,
  input logic [1:0] frm_kind,
  input logic       txd_o,
  input logic       rts_o,
  input logic       dtr_o,
  input logic       irq_o,
  input logic       en,
  input logic       tx_busy,
  input logic [7:0] ist,
  input logic [7:0] imask,
  input logic       rx_done
);
  // R11
  tx_idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> txd_o);

  // R7
  busy_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !ist[1]);

  // R8
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !(frm_vld && frm_kind == 2'b00)) |=> ist[0]);

  // R4
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (imask != 8'h00));

  // R3
  null_word_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_kind == 2'b00) |=> (ist == 8'h02 && imask == 8'h00 && !rts_o && !dtr_o));
endmodule

bind sbu_uart_slave sbu_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_kind(frm_word[9:8]),
  .txd_o(txd_o), .rts_o(rts_o), .dtr_o(dtr_o), .irq_o(irq_o),
  .en(en_q), .tx_busy(tx_busy), .ist(ist_q), .imask(imask_q), .rx_done(rx_done));

// File: tb/tb_sbu_uart_slave.sv
module tb_sbu_uart_slave;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       frm_vld;
  logic [9:0] frm_word;
  logic [7:0] rd_data;
  logic       rxd_i, txd_o, cts_i, dsr_i, dcd_i, rts_o, dtr_o, irq_o;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sbu_uart_slave dut (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_word(frm_word),
    .rd_data(rd_data), .rxd_i(rxd_i), .txd_o(txd_o), .cts_i(cts_i),
    .dsr_i(dsr_i), .dcd_i(dcd_i), .rts_o(rts_o), .dtr_o(dtr_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] kind, input logic [7:0] b);
    @(negedge clk);
    frm_vld  = 1'b1;
    frm_word = {kind, b};
    @(negedge clk);
    frm_vld  = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    send(2'b01, {4'h8, a});
    send(2'b10, d);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    send(2'b01, {4'hC, a});
    send(2'b10, 8'h00);
    d = rd_data;
  endtask

  task automatic wait_low();
    int t = 0;
    while (txd_o !== 1'b0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic tx_cap(input int nb, input int bc, output logic [15:0] v);
    v = '0;
    wait_low();
    repeat (bc/2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      v[i] = txd_o;
      repeat (bc) @(negedge clk);
    end
  endtask

  task automatic low_len(output int n);
    n = 0;
    wait_low();
    while (txd_o === 1'b0 && n < 70000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rx_send(input logic [15:0] bits, input int nb, input int bc);
    for (int i = 0; i < nb; i++) begin
      rxd_i = bits[i];
      repeat (bc) @(negedge clk);
    end
    rxd_i = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R1 txd idle", txd_o, 1);
    chk("R1 rts", rts_o, 0);
    chk("R1 dtr", dtr_o, 0);
    chk("R1 irq", irq_o, 0);
    rd(4'h6, r); chk("R1 mask", r, 8'h00);
    wr(4'h6, 8'hFF);
    rd(4'h7, r); chk("R1 status reset value", r, 8'h02);
  endtask

  task automatic t_frames();
    logic [7:0] r;
    chk("R4 irq with mask", irq_o, 1);
    wr(4'h6, 8'h5A);
    rd(4'h6, r); chk("R2 write/read mask", r, 8'h5A);
    send(2'b01, 8'h46); send(2'b10, 8'h33);
    rd(4'h6, r); chk("R2 select leaves reg", r, 8'h5A);
    wr(4'h6, 8'h01);
    chk("R4 irq masked off", irq_o, 0);
    rd(4'h7, r); chk("R4 masked status", r, 8'h00);
    wr(4'h6, 8'hFF);
  endtask

  task automatic t_enable();
    logic [7:0] r;
    wr(4'h3, 8'h06);
    chk("R11 rts held off", rts_o, 0);
    chk("R11 dtr held off", dtr_o, 0);
    wr(4'h9, 8'h55);
    repeat (100) @(negedge clk);
    chk("R11 txd idle when off", txd_o, 1);
    rd(4'h7, r); chk("R11 empty flag kept", r[1], 1);
    wr(4'h2, 8'h01);
    wr(4'h3, 8'h06);
    chk("R11 rts", rts_o, 1);
    chk("R11 dtr", dtr_o, 1);
    wr(4'h3, 8'h02);
    chk("R11 dtr from bit2", dtr_o, 0);
  endtask

  task automatic t_tx_basic();
    logic [15:0] v;
    wr(4'h8, 8'h06);
    wr(4'h9, 8'hA5);
    tx_cap(10, 16, v);
    chk("R5 8N1 frame", v[9:0], {1'b1, 8'hA5, 1'b0});
  endtask

  task automatic t_tx_status();
    logic [7:0] r;
    wr(4'h9, 8'hC3);
    rd(4'h7, r); chk("R7 empty cleared", r[1], 0);
    rd(4'h8, r); chk("R7 busy/empty during", r[4:3], 2'b10);
    repeat (200) @(negedge clk);
    rd(4'h7, r); chk("R7 empty set after", r[1], 1);
    rd(4'h8, r); chk("R7 busy/empty after", r[4:3], 2'b01);
  endtask

  task automatic t_tx_parity();
    logic [15:0] v;
    logic [6:0]  d;
    logic        p;
    d = 7'h35;
    p = ~(^d);
    wr(4'h8, 8'h3C);
    wr(4'h9, {1'b0, d});
    tx_cap(11, 16, v);
    chk("R5 7O2 frame", v[10:0], {2'b11, p, d, 1'b0});
  endtask

  task automatic t_baud();
    int n;
    wr(4'hA, 8'hFC);
    wr(4'h9, 8'hFF);
    low_len(n);
    chk("R6 low-byte divisor", n, 64);
    repeat (64 * 12) @(negedge clk);
    wr(4'hB, 8'hFE);
    wr(4'hA, 8'hFF);
    wr(4'h9, 8'hFF);
    low_len(n);
    chk("R6 high-byte divisor", n, 16 * 257);
    wr(4'h2, 8'h00);
    wr(4'hB, 8'hFF);
    wr(4'hA, 8'hFF);
    wr(4'h2, 8'h01);
  endtask

  task automatic t_rx();
    logic [7:0] r;
    wr(4'h8, 8'h06);
    rx_send({6'h3F, 1'b1, 8'h3C, 1'b0}, 10, 16);
    repeat (40) @(negedge clk);
    rd(4'h7, r); chk("R8 rx flag", r[0], 1);
    rd(4'h8, r); chk("R8 data waiting", r[5], 1);
    rd(4'h9, r); chk("R8 rx char", r, 8'h3C);
    rd(4'h7, r); chk("R8 rx flag cleared", r[0], 0);
    rd(4'h8, r); chk("R8 waiting cleared", r[5], 0);
  endtask

  task automatic t_rx_err();
    logic [7:0] r;
    rx_send({7'h00, 8'h55, 1'b0}, 9, 16);
    rxd_i = 1'b0;
    repeat (12) @(negedge clk);
    rxd_i = 1'b1;
    repeat (60) @(negedge clk);
    rd(4'h7, r); chk("R9 error flag framing", r[2], 1);
    rd(4'h8, r); chk("R9 framing bit", r[7:6], 2'b01);
    rd(4'h7, r); chk("R9 error flag cleared", r[2], 0);
    rd(4'h9, r);
    wr(4'h8, 8'h0E);
    rx_send({5'h1F, 1'b1, 1'b0, 8'h01, 1'b0}, 11, 16);
    repeat (40) @(negedge clk);
    rd(4'h7, r); chk("R9 error flag parity", r[2], 1);
    rd(4'h8, r); chk("R9 parity bit", r[7:6], 2'b10);
    rd(4'h9, r);
  endtask

  task automatic t_modem();
    logic [7:0] r;
    rd(4'h7, r); chk("R10 quiet before", r[2], 0);
    cts_i = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'h7, r); chk("R10 change flag", r[2], 1);
    rd(4'h8, r); chk("R10 line levels", r[2:0], 3'b001);
    rd(4'h7, r); chk("R10 flag cleared", r[2], 0);
  endtask

  task automatic t_null();
    logic [7:0] r;
    int         n;
    send(2'b00, 8'h00);
    chk("R3 irq after null", irq_o, 0);
    chk("R3 rts after null", rts_o, 0);
    rd(4'h6, r); chk("R3 mask", r, 8'h00);
    wr(4'h6, 8'hFF);
    rd(4'h7, r); chk("R3 status", r, 8'h02);
    wr(4'h2, 8'h01);
    wr(4'h9, 8'h1F);
    low_len(n);
    chk("R3 divisor back to 0xFFFF", n, 16);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frm_vld = 1'b0; frm_word = '0;
    rxd_i = 1'b1; cts_i = 1'b0; dsr_i = 1'b0; dcd_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_frames();
    t_enable();
    t_tx_basic();
    t_tx_status();
    t_tx_parity();
    t_baud();
    t_rx();
    t_rx_err();
    t_modem();
    t_null();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule